// File: doc/BRIEF.md
# I2C Target Controller with Masked Address Compare

This block is a clocked I2C target (slave) for a large chip. It oversamples the bus clock and data lines with the system clock. It detects bus conditions and bit edges, and moves bytes through an internal shift register that the host cannot reach. A programmable own address and a per-bit ignore mask decide which address bytes it answers. Addressing is either 7-bit or 10-bit. The block pulls the data line low only to acknowledge a byte or to send a byte as transmitter. At every other time it leaves the line to the pull-up.

START and STOP conditions each raise a one-cycle pulse and set a sticky flag. Firmware can use these to run a bus master in software. The block has no general-call behaviour: address zero is answered only when the address and mask registers select it. The host sees received bytes through a holding register with a full flag and an overflow flag. It supplies the byte to transmit through a write strobe.

Top module: `i2c_mask_target`

## Requirements
- R1: While `enable` is low, `sdaOe` stays low, no byte is acknowledged and neither START nor STOP sets a flag.
- R2: SDA falling while SCL is high is a START: `startPulse` is high for one cycle and `startFlag` sets. SDA rising while SCL is high is a STOP: `stopPulse` is high for one cycle and `stopFlag` sets. `flagClr` clears both flags.
- R3: In 7-bit mode, the first byte after a START (sent MSB first) carries the address in bits 7:1 and the direction in bit 0 (1 = read). It is acknowledged when `ownAddr[6:0]` matches it in every position where `addrMask` is 0. Positions where `addrMask` is 1 are ignored. A byte that does not match is not acknowledged, and the block stays off the line until the next START.
- R4: In 10-bit mode, a first byte of binary 11110, then A9 A8, then 0 (write) is acknowledged when `ownAddr[9:8]` matches under the mask. The next byte is acknowledged when it matches `ownAddr[7:0]` under the mask.
- R5: In 10-bit mode, a header byte with bit 0 set (read) is acknowledged only after a complete 10-bit write match since the last STOP. The block then transmits.
- R6: Address zero gets no special treatment: it is acknowledged only when the own address and mask match it.
- R7: Data bytes written to a matched target are acknowledged, copied to `rxData` and set `rxFull`. A one-cycle `rxRead` clears `rxFull`.
- R8: A data byte that completes while `rxFull` is set is not acknowledged. It sets `rxOverflow`, and `rxData` keeps its old byte. `flagClr` clears `rxOverflow`.
- R9: If `rxRead` is high in the same cycle that a received byte completes, the byte is accepted and acknowledged, `rxFull` stays set, and `rxOverflow` does not set.
- R10: As transmitter, the block sends the byte last loaded with `txWrite`, MSB first. The data line changes only after SCL falls and is steady while SCL is high.
- R11: When the master does not acknowledge a transmitted byte, the transfer ends and the block releases SDA until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns the whole block on |
| addr10Mode | input | 1 | 1 selects 10-bit addressing |
| ownAddr | input | 10 | Own target address (7-bit mode uses bits 6:0) |
| addrMask | input | 10 | 1 in a bit ignores that address bit |
| txData | input | 8 | Byte to transmit |
| txWrite | input | 1 | Loads txData into the transmit holding register |
| rxRead | input | 1 | Host read strobe; clears rxFull |
| flagClr | input | 1 | Clears startFlag, stopFlag and rxOverflow |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low |
| rxData | output | 8 | Last accepted received byte |
| rxFull | output | 1 | Received byte waiting for the host |
| rxOverflow | output | 1 | A byte was refused because the buffer was full |
| startPulse | output | 1 | One-cycle pulse on a START |
| stopPulse | output | 1 | One-cycle pulse on a STOP |
| startFlag | output | 1 | Sticky START flag |
| stopFlag | output | 1 | Sticky STOP flag |

## Verification
A host read of the holding register can fall in the same cycle as the bus-side completion of a new byte. The block's answer to that byte (acknowledge or refuse) depends on the order in which it resolves the two. The bench fills the buffer, then sends another byte. It counts the synchronizer and edge-detect stages so that `rxRead` is high exactly in the cycle when the controller sees the eighth falling clock edge. It judges the result by the acknowledge seen on the bus, the new `rxData`, `rxFull` still set, and `rxOverflow` still clear.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int A7_W   = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } stateT;

  typedef enum logic [1:0] {
    K_ADDR1,
    K_ADDR2,
    K_DATA
  } kindT;

  typedef struct packed {
    logic shiftIn;
    logic loadRx;
    logic setOvf;
    logic loadTx;
    logic shiftTx;
  } strobeT;
endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              flagClr,
  input  strobeT            strb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              sclHigh,
  output logic              startEv,
  output logic              stopEv,
  output logic              sdaBit,
  output logic              rwBit,
  output logic              match7,
  output logic              matchHdr,
  output logic              matchLow,
  output logic              txBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverflow,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              startFlag,
  output logic              stopFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] rxSr, txSr, txBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[LAST];
  assign sdaS    = sdaPipe[LAST];
  assign sdaBit  = sdaS;
  assign sclHigh = sclS & sclPrev;
  assign sclRise = enable & sclS & ~sclPrev;
  assign sclFall = enable & ~sclS & sclPrev;
  assign startEv = enable & sclHigh & sdaPrev & ~sdaS;
  assign stopEv  = enable & sclHigh & ~sdaPrev & sdaS;

  // address compare, masked positions ignored
  assign rwBit    = rxSr[0];
  assign match7   = ((rxSr[BYTE_W-1:1] ^ ownAddr[A7_W-1:0]) & ~addrMask[A7_W-1:0]) == '0;
  assign matchHdr = (rxSr[BYTE_W-1:3] == HDR10) &&
                    (((rxSr[2:1] ^ ownAddr[ADDR_W-1:ADDR_W-2]) & ~addrMask[ADDR_W-1:ADDR_W-2]) == '0);
  assign matchLow = ((rxSr ^ ownAddr[BYTE_W-1:0]) & ~addrMask[BYTE_W-1:0]) == '0;
  assign txBit    = txSr[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSr       <= '0;
      txSr       <= '1;
      txBuf      <= '0;
      rxData     <= '0;
      rxFull     <= 1'b0;
      rxOverflow <= 1'b0;
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
      startFlag  <= 1'b0;
      stopFlag   <= 1'b0;
    end else begin
      startPulse <= startEv;
      stopPulse  <= stopEv;
      if (strb.shiftIn) rxSr <= {rxSr[BYTE_W-2:0], sdaS};
      if (txWrite) txBuf <= txData;
      if (strb.loadTx) txSr <= txBuf;
      else if (strb.shiftTx) txSr <= {txSr[BYTE_W-2:0], 1'b1};
      if (strb.loadRx) rxData <= rxSr;
      // a load in the same cycle as a host read wins
      if (strb.loadRx) rxFull <= 1'b1;
      else if (rxRead) rxFull <= 1'b0;
      if (strb.setOvf) rxOverflow <= 1'b1;
      else if (flagClr) rxOverflow <= 1'b0;
      if (startEv) startFlag <= 1'b1;
      else if (flagClr) startFlag <= 1'b0;
      if (stopEv) stopFlag <= 1'b1;
      else if (flagClr) stopFlag <= 1'b0;
    end
  end

  p_start_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startFlag) |-> startPulse);

  p_ovf_when_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverflow) |-> $past(rxFull));

  p_read_collision_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRx && rxRead) |=> (rxFull && !$rose(rxOverflow)));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   addr10Mode,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   sclHigh,
  input  logic   startEv,
  input  logic   stopEv,
  input  logic   sdaBit,
  input  logic   rwBit,
  input  logic   match7,
  input  logic   matchHdr,
  input  logic   matchLow,
  input  logic   txBit,
  input  logic   rxFull,
  input  logic   rxRead,
  output strobeT strb,
  output logic   sdaOe
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  stateT state;
  kindT  kind, nextKind;
  logic [CNT_W-1:0] bitCnt;
  logic goTx, matched10;
  logic ackNow, txNext, match10Next, decide;

  // acknowledge decision for the byte just received
  always_comb begin
    ackNow      = 1'b0;
    txNext      = 1'b0;
    nextKind    = K_DATA;
    match10Next = matched10;
    case (kind)
      K_ADDR1: begin
        if (!addr10Mode) begin
          ackNow = match7;
          txNext = rwBit;
        end else if (matchHdr && !rwBit) begin
          ackNow      = 1'b1;
          nextKind    = K_ADDR2;
          match10Next = 1'b0;
        end else if (matchHdr) begin
          ackNow = matched10;
          txNext = 1'b1;
        end
        if (!ackNow) match10Next = 1'b0;
      end
      K_ADDR2: begin
        ackNow      = matchLow;
        match10Next = matchLow;
      end
      default: ackNow = !(rxFull && !rxRead);
    endcase
  end

  assign decide = (state == ST_RX) && sclFall && (bitCnt == FULL_CNT);

  always_comb begin
    strb.shiftIn = (state == ST_RX) && sclRise && (bitCnt < FULL_CNT);
    strb.loadRx  = decide && (kind == K_DATA) && ackNow;
    strb.setOvf  = decide && (kind == K_DATA) && !ackNow;
    strb.loadTx  = sclFall && (((state == ST_ACK) && goTx) || (state == ST_TXACK));
    strb.shiftTx = (state == ST_TX) && sclFall && (bitCnt != FULL_CNT);
  end

  assign sdaOe = enable && ((state == ST_ACK) || ((state == ST_TX) && !txBit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR1;
      bitCnt    <= '0;
      goTx      <= 1'b0;
      matched10 <= 1'b0;
    end else if (!enable || stopEv) begin
      state     <= ST_IDLE;
      matched10 <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RX;
      kind   <= K_ADDR1;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_RX: begin
          if (strb.shiftIn) bitCnt <= bitCnt + 1'b1;
          if (decide) begin
            if (kind != K_DATA) matched10 <= match10Next;
            if (ackNow) begin
              state <= ST_ACK;
              goTx  <= (kind == K_DATA) ? 1'b0 : txNext;
              kind  <= nextKind;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: if (sclFall) begin
          state  <= goTx ? ST_TX : ST_RX;
          bitCnt <= '0;
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == FULL_CNT) state <= ST_TXACK;
        end
        ST_TXACK: begin
          if (sclRise && sdaBit) state <= ST_IDLE;
          else if (sclFall) begin
            state  <= ST_TX;
            bitCnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE && !sdaOe));

  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rstN || !enable)
    (sclHigh && $past(sclHigh)) |-> $stable(sdaOe));

  p_no_load_on_refuse_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOvf |-> !strb.loadRx);

  p_tx_ack_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_TXACK) && sclRise && sdaBit && !startEv && !stopEv && enable) |=> !sdaOe);
endmodule

// File: rtl/i2c_mask_target.sv
module i2c_mask_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              addr10Mode,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              flagClr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverflow,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              startFlag,
  output logic              stopFlag
);
  strobeT strb;
  logic sclRise, sclFall, sclHigh, startEv, stopEv, sdaBit, rwBit;
  logic match7, matchHdr, matchLow, txBit;

  i2c_tgt_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .addrMask(addrMask), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .flagClr(flagClr), .strb(strb),
    .sclRise(sclRise), .sclFall(sclFall), .sclHigh(sclHigh),
    .startEv(startEv), .stopEv(stopEv), .sdaBit(sdaBit), .rwBit(rwBit),
    .match7(match7), .matchHdr(matchHdr), .matchLow(matchLow), .txBit(txBit),
    .rxData(rxData), .rxFull(rxFull), .rxOverflow(rxOverflow),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .startFlag(startFlag), .stopFlag(stopFlag)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .addr10Mode(addr10Mode),
    .sclRise(sclRise), .sclFall(sclFall), .sclHigh(sclHigh),
    .startEv(startEv), .stopEv(stopEv), .sdaBit(sdaBit), .rwBit(rwBit),
    .match7(match7), .matchHdr(matchHdr), .matchLow(matchLow), .txBit(txBit),
    .rxFull(rxFull), .rxRead(rxRead), .strb(strb), .sdaOe(sdaOe)
  );
endmodule

// File: tb/i2c_mask_target_tb.sv
`timescale 1ns/1ps
module i2c_mask_target_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN, enable, addr10Mode, txWrite, rxRead, flagClr;
  logic [9:0] ownAddr, addrMask;
  logic [7:0] txData;
  logic sclM, sdaM, busSda;
  logic sdaOe, rxFull, rxOverflow, startPulse, stopPulse, startFlag, stopFlag;
  logic [7:0] rxData;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign busSda = sdaM & ~sdaOe;

  i2c_mask_target u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .addr10Mode(addr10Mode),
    .ownAddr(ownAddr), .addrMask(addrMask), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .flagClr(flagClr), .sclIn(sclM), .sdaIn(busSda),
    .sdaOe(sdaOe), .rxData(rxData), .rxFull(rxFull), .rxOverflow(rxOverflow),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .startFlag(startFlag), .stopFlag(stopFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit expMatch7(input logic [6:0] a, input logic [9:0] own, input logic [9:0] msk);
    return ((a ^ own[6:0]) & ~msk[6:0]) == 7'd0;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRead();
    rxRead = 1'b1; hold(1); rxRead = 1'b0; hold(1);
  endtask

  task automatic pulseClr();
    flagClr = 1'b1; hold(1); flagClr = 1'b0; hold(1);
  endtask

  task automatic loadTx(input logic [7:0] b);
    txData = b; txWrite = 1'b1; hold(1); txWrite = 1'b0; hold(1);
  endtask

  task automatic doStart();
    sdaM = 1'b1; hold(H); sclM = 1'b1; hold(H);
    sdaM = 1'b0; hold(H); sclM = 1'b0; hold(H);
  endtask

  task automatic doStop();
    sdaM = 1'b0; hold(H); sclM = 1'b1; hold(H); sdaM = 1'b1; hold(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit collide, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hold(H); sclM = 1'b1; hold(H); sclM = 1'b0;
      if (i == 0 && collide) begin
        // two sync flops plus the edge register: decision at the third edge
        hold(2); rxRead = 1'b1; hold(1); rxRead = 1'b0; hold(H - 3);
      end else begin
        hold(H);
      end
    end
    sdaM = 1'b1; hold(H); sclM = 1'b1; hold(H);
    acked = sdaOe;
    sclM = 1'b0; hold(H);
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] b, output bit steady);
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); sclM = 1'b1; hold(1);
      b[i] = busSda; hold(H - 1);
      if (busSda !== b[i]) steady = 1'b0;
      sclM = 1'b0;
    end
    hold(H); sdaM = !masterAck; hold(H); sclM = 1'b1; hold(H);
    sclM = 1'b0; hold(H); sdaM = 1'b1;
  endtask

  initial begin
    bit ack, st;
    logic [7:0] rb;
    void'($urandom(32'd2024));
    rstN = 1'b0; enable = 1'b0; addr10Mode = 1'b0; txWrite = 1'b0; rxRead = 1'b0;
    flagClr = 1'b0; ownAddr = 10'h02A; addrMask = '0; txData = '0;
    sclM = 1'b1; sdaM = 1'b1;
    hold(5); rstN = 1'b1; hold(2);

    chk("R1 reset sdaOe", sdaOe, 0);
    chk("R7 reset rxFull", rxFull, 0);
    chk("R2 reset flags", {startFlag, stopFlag, rxOverflow}, 0);

    // R1: disabled block ignores a matching transfer
    doStart(); sendByte({7'h2A, 1'b0}, 0, ack);
    chk("R1 no ack while off", ack, 0);
    doStop();
    chk("R1 no flags while off", {startFlag, stopFlag}, 0);

    enable = 1'b1; hold(4);
    // R2
    doStart();
    chk("R2 start flag", {startFlag, stopFlag}, 2'b10);
    doStop();
    chk("R2 stop flag", stopFlag, 1);
    pulseClr();
    chk("R2 flags cleared", {startFlag, stopFlag}, 0);

    // R3 / R7 / R8
    doStart(); sendByte({7'h2A, 1'b0}, 0, ack);
    chk("R3 address ack", ack, 1);
    sendByte(8'h5C, 0, ack);
    chk("R7 data ack", ack, 1);
    chk("R7 rxData", rxData, 8'h5C);
    chk("R7 rxFull set", rxFull, 1);
    pulseRead();
    chk("R7 rxFull cleared", rxFull, 0);
    sendByte(8'h11, 0, ack);
    chk("R7 second ack", ack, 1);
    sendByte(8'h22, 0, ack);
    chk("R8 refused", ack, 0);
    chk("R8 overflow set", rxOverflow, 1);
    chk("R8 data kept", rxData, 8'h11);
    doStop(); pulseClr();
    chk("R8 overflow cleared", rxOverflow, 0);

    // R9: host read coincides with byte completion
    doStart(); sendByte({7'h2A, 1'b0}, 0, ack);
    sendByte(8'h33, 1, ack);
    chk("R9 ack on collision", ack, 1);
    chk("R9 new data", rxData, 8'h33);
    chk("R9 full stays", {rxFull, rxOverflow}, 2'b10);
    doStop(); pulseRead();

    // R3 random masked compare
    for (int n = 0; n < 24; n++) begin
      logic [6:0] a;
      ownAddr  = 10'($urandom());
      addrMask = 10'($urandom() & $urandom());
      a = (n % 2 == 0) ? (ownAddr[6:0] ^ (7'($urandom()) & addrMask[6:0])) : 7'($urandom());
      doStart(); sendByte({a, 1'b0}, 0, ack);
      chk("R3 masked compare", ack, expMatch7(a, ownAddr, addrMask));
      doStop();
    end

    // R6
    ownAddr = 10'h015; addrMask = '0;
    doStart(); sendByte(8'h00, 0, ack);
    chk("R6 zero not general call", ack, 0);
    doStop();
    ownAddr = 10'h000;
    doStart(); sendByte(8'h00, 0, ack);
    chk("R6 zero via registers", ack, 1);
    doStop();

    // R10 / R11: 7-bit read
    ownAddr = 10'h02A; loadTx(8'hA5);
    doStart(); sendByte({7'h2A, 1'b1}, 0, ack);
    chk("R10 read address ack", ack, 1);
    loadTx(8'h3C);
    recvByte(1, rb, st);
    chk("R10 first byte", rb, 8'hA5);
    chk("R10 steady while high", st, 1);
    recvByte(0, rb, st);
    chk("R10 second byte", rb, 8'h3C);
    recvByte(0, rb, st);
    chk("R11 released after nack", rb, 8'hFF);
    doStop();

    // R4 / R5: 10-bit
    addr10Mode = 1'b1; ownAddr = 10'h2B7; addrMask = '0;
    doStart(); sendByte({5'b11110, ownAddr[9:8], 1'b0}, 0, ack);
    chk("R4 header ack", ack, 1);
    sendByte(ownAddr[7:0], 0, ack);
    chk("R4 low byte ack", ack, 1);
    sendByte(8'h77, 0, ack);
    chk("R4 data", {ack, rxData}, {1'b1, 8'h77});
    pulseRead(); loadTx(8'hC3);
    doStart(); sendByte({5'b11110, ownAddr[9:8], 1'b1}, 0, ack);
    chk("R5 read header ack", ack, 1);
    recvByte(0, rb, st);
    chk("R5 transmit byte", rb, 8'hC3);
    doStop();
    doStart(); sendByte({5'b11110, ownAddr[9:8], 1'b1}, 0, ack);
    chk("R5 read header without match", ack, 0);
    doStop();
    doStart(); sendByte({5'b11110, ownAddr[9:8], 1'b0}, 0, ack);
    sendByte(ownAddr[7:0] ^ 8'h01, 0, ack);
    chk("R4 low byte mismatch", ack, 0);
    doStop();
    addrMask = 10'h100;
    doStart(); sendByte({5'b11110, ownAddr[9], ~ownAddr[8], 1'b0}, 0, ack);
    chk("R4 masked header bit", ack, 1);
    sendByte(ownAddr[7:0], 0, ack);
    chk("R4 masked low ack", ack, 1);
    doStop();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule